// File: doc/BRIEF.md
# Ternary CAM Slice Depth-Cascade Flag Controller

This block is the flag logic of one slice of a ternary content-addressable memory. It lets several identical slices be chained in priority order with no logic between them. Each slice receives its own local compare results: hit, multiple hit and full. It also receives the flag and cascade lines from its neighbours in the chain. From these it produces the lines it passes on to those neighbours. The memory array itself is outside this block; the bench stands in for it by driving the local flags directly.

Match information runs in both directions. A "down" match flag travels from higher-priority slices towards lower-priority ones, and an "up" match flag travels the other way. The multiple-match, full and system-match indications follow the down direction, so the lowest-priority slice presents the system-wide result. The chip select is sampled on the clock and is active low. A deselected slice in a chain becomes transparent and forwards each incoming line to the matching outgoing line. A deselected standalone slice, chosen by a parameter, drives fixed idle levels instead.

Every output is registered and changes one clock after the inputs that cause it. The match-related outputs are refreshed only on cycles that carry a compare. The full output is refreshed on every cycle in which the slice is selected.

Top module: `tcam_casc_flags`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it is released, the active-low outputs `mdn_out_n`, `mup_out_n`, `mm_out_n`, `sys_match_n` and `full_out_n` are 1 and the active-high outputs `cdn_out` and `cup_out` are 0.
- R2: On an edge with `sel_n`=0 and `cmp_en`=1, `mdn_out_n` becomes 0 if `loc_hit`=1 or `mdn_in_n`=0, and becomes 1 otherwise.
- R3: On an edge with `sel_n`=0 and `cmp_en`=1, `mup_out_n` becomes 0 if `loc_hit`=1 or `mup_in_n`=0, and becomes 1 otherwise.
- R4: On an edge with `sel_n`=0 and `cmp_en`=1, `mm_out_n` becomes 0 if `loc_multi`=1, or `mm_in_n`=0, or `loc_hit`=1 while `mdn_in_n`=0; otherwise it becomes 1.
- R5: `sys_match_n` always equals `mdn_out_n`, in every mode and every cycle.
- R6: On an edge with `sel_n`=0 and `cmp_en`=0, `mdn_out_n`, `mup_out_n`, `mm_out_n`, `sys_match_n`, `cdn_out` and `cup_out` keep their values, whatever the local flags and chain inputs are.
- R7: On an edge with `sel_n`=0, `full_out_n` becomes 0 if `loc_full`=1 and `full_in_n`=0, and becomes 1 otherwise. This happens whether or not a compare is present.
- R8: With `CASCADE`=1, on an edge with `sel_n`=1, each output takes the level of its input one cycle later: `mdn_in_n` goes to both `mdn_out_n` and `sys_match_n`, `mup_in_n` to `mup_out_n`, `mm_in_n` to `mm_out_n`, `full_in_n` to `full_out_n`, `cdn_in` to `cdn_out` and `cup_in` to `cup_out`.
- R9: With `CASCADE`=0, on an edge with `sel_n`=1, `mdn_out_n`, `mup_out_n`, `mm_out_n` and `sys_match_n` become 1, and `full_out_n`, `cdn_out` and `cup_out` become 0.
- R10: On an edge with `sel_n`=0 and `cmp_en`=1, `cdn_out` becomes `cdn_in` OR `loc_hit`, and `cup_out` becomes `cup_in` OR `loc_hit`. Both are active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Slice select, active low |
| cmp_en | input | 1 | A compare is performed this cycle |
| loc_hit | input | 1 | Local array reports at least one hit |
| loc_multi | input | 1 | Local array reports more than one hit |
| loc_full | input | 1 | Local array has no free entry |
| mdn_in_n | input | 1 | Down match flag from the higher-priority neighbour, active low |
| mup_in_n | input | 1 | Up match flag from the lower-priority neighbour, active low |
| mm_in_n | input | 1 | Multiple-match flag from the higher-priority neighbour, active low |
| full_in_n | input | 1 | Full flag from the higher-priority neighbour, active low |
| cdn_in | input | 1 | Cascade claim from the higher-priority side |
| cup_in | input | 1 | Cascade claim from the lower-priority side |
| mdn_out_n | output | 1 | Down match flag toward the lower-priority neighbour, active low |
| mup_out_n | output | 1 | Up match flag toward the higher-priority neighbour, active low |
| mm_out_n | output | 1 | Multiple-match flag, active low |
| full_out_n | output | 1 | Full flag, active low |
| cdn_out | output | 1 | Cascade claim toward the lower-priority side |
| cup_out | output | 1 | Cascade claim toward the higher-priority side |
| sys_match_n | output | 1 | System match flag, active low |

## Verification
Assertions are checked on every cycle for the following:
- the system flag mirrors the down match flag;
- the flags hold when a selected slice sees no compare;
- a chained slice is transparent when it is deselected;
- a standalone slice drives its idle levels when it is deselected;
- a local hit forces the down match, up match and cascade claims;
- a hit behind an upstream match forces the multiple-match flag;
- a slice that is not locally full releases the full flag.

Some behaviours can only be shown by the bench's scenarios. One is that a slice stays inactive when there is no hit and no upstream flag. Another is the exact combination of upstream full and local full. A third is the reset levels. The last is that a chained slice and a standalone slice driven by the same stimulus produce the distinct results each mode calls for.

// File: rtl/tcam_casc_pkg.sv
package tcam_casc_pkg;

    // Index of each registered flag in the flag vector
    localparam int NUM_FLAGS = 7;
    localparam int F_MDN  = 0;
    localparam int F_MUP  = 1;
    localparam int F_MM   = 2;
    localparam int F_SYS  = 3;
    localparam int F_FULL = 4;
    localparam int F_CDN  = 5;
    localparam int F_CUP  = 6;

    // Local results coming from the slice's memory array
    typedef struct packed {
        logic hit;
        logic multi;
        logic full;
    } local_flags_t;

    // Lines arriving from the neighbouring slices (pin levels)
    typedef struct packed {
        logic mdn_n;
        logic mup_n;
        logic mm_n;
        logic full_n;
        logic cdn;
        logic cup;
    } chain_in_t;

    // Pin level after reset
    function automatic logic reset_level(input int idx);
        return (idx == F_CDN || idx == F_CUP) ? 1'b0 : 1'b1;
    endfunction

    // Pin level of a deselected standalone slice
    function automatic logic idle_level(input int idx);
        return (idx == F_MDN || idx == F_MUP || idx == F_MM || idx == F_SYS);
    endfunction

    // Flags refreshed on every selected cycle rather than on compares only
    function automatic logic every_cycle(input int idx);
        return idx == F_FULL;
    endfunction

endpackage

// File: rtl/tcam_casc_eval.sv
module tcam_casc_eval
    import tcam_casc_pkg::*;
(
    input  local_flags_t           loc,
    input  chain_in_t              chin,
    output logic [NUM_FLAGS-1:0]   nxt_sel,
    output logic [NUM_FLAGS-1:0]   nxt_pass
);

    logic up_match;   // match already seen by a higher-priority slice
    logic low_match;  // match already seen by a lower-priority slice

    always_comb begin
        up_match  = ~chin.mdn_n;
        low_match = ~chin.mup_n;

        // Levels driven by a selected slice
        nxt_sel          = '0;
        nxt_sel[F_MDN]   = ~(loc.hit | up_match);
        nxt_sel[F_SYS]   = ~(loc.hit | up_match);
        nxt_sel[F_MUP]   = ~(loc.hit | low_match);
        nxt_sel[F_MM]    = ~(loc.multi | ~chin.mm_n | (loc.hit & up_match));
        nxt_sel[F_FULL]  = ~(loc.full & ~chin.full_n);
        nxt_sel[F_CDN]   = chin.cdn | loc.hit;
        nxt_sel[F_CUP]   = chin.cup | loc.hit;

        // Levels forwarded by a transparent (deselected, chained) slice
        nxt_pass         = '0;
        nxt_pass[F_MDN]  = chin.mdn_n;
        nxt_pass[F_SYS]  = chin.mdn_n;
        nxt_pass[F_MUP]  = chin.mup_n;
        nxt_pass[F_MM]   = chin.mm_n;
        nxt_pass[F_FULL] = chin.full_n;
        nxt_pass[F_CDN]  = chin.cdn;
        nxt_pass[F_CUP]  = chin.cup;
    end

endmodule

// File: rtl/tcam_casc_cell.sv
module tcam_casc_cell #(
    parameter bit RST_VAL  = 1'b1,
    parameter bit IDLE_VAL = 1'b1,
    parameter bit CASCADE  = 1'b1,
    parameter bit EVERY    = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_n,
    input  logic cmp_en,
    input  logic nxt_sel,
    input  logic nxt_pass,
    output logic q
);

    localparam bit TRANSPARENT = CASCADE;

    logic upd;
    assign upd = EVERY ? 1'b1 : cmp_en;

    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VAL;
        else if (sel_n)
            q <= TRANSPARENT ? nxt_pass : IDLE_VAL;
        else if (upd)
            q <= nxt_sel;
    end

    // R6: a selected slice with no compare keeps compare-driven flags
    generate
        if (!EVERY) begin : g_hold_chk
            assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
                (!sel_n && !cmp_en) |=> $stable(q));
        end
        if (CASCADE) begin : g_pass_chk
            // R8: deselected chained slice forwards its input one cycle later
            assert_pass_R8: assert property (@(posedge clk) disable iff (rst)
                sel_n |=> (q == $past(nxt_pass)));
        end else begin : g_idle_chk
            // R9: deselected standalone slice drives its idle level
            assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
                sel_n |=> (q == IDLE_VAL));
        end
    endgenerate

endmodule

// File: rtl/tcam_casc_flags.sv
module tcam_casc_flags
    import tcam_casc_pkg::*;
#(
    parameter bit CASCADE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_n,
    input  logic cmp_en,
    input  logic loc_hit,
    input  logic loc_multi,
    input  logic loc_full,
    input  logic mdn_in_n,
    input  logic mup_in_n,
    input  logic mm_in_n,
    input  logic full_in_n,
    input  logic cdn_in,
    input  logic cup_in,
    output logic mdn_out_n,
    output logic mup_out_n,
    output logic mm_out_n,
    output logic full_out_n,
    output logic cdn_out,
    output logic cup_out,
    output logic sys_match_n
);

    local_flags_t         loc;
    chain_in_t            chin;
    logic [NUM_FLAGS-1:0] nxt_sel;
    logic [NUM_FLAGS-1:0] nxt_pass;
    logic [NUM_FLAGS-1:0] flag_q;

    assign loc  = '{hit: loc_hit, multi: loc_multi, full: loc_full};
    assign chin = '{mdn_n: mdn_in_n, mup_n: mup_in_n, mm_n: mm_in_n,
                    full_n: full_in_n, cdn: cdn_in, cup: cup_in};

    tcam_casc_eval u_eval (
        .loc      (loc),
        .chin     (chin),
        .nxt_sel  (nxt_sel),
        .nxt_pass (nxt_pass)
    );

    generate
        for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_cell
            tcam_casc_cell #(
                .RST_VAL  (reset_level(i)),
                .IDLE_VAL (idle_level(i)),
                .CASCADE  (CASCADE),
                .EVERY    (every_cycle(i))
            ) u_cell (
                .clk      (clk),
                .rst      (rst),
                .sel_n    (sel_n),
                .cmp_en   (cmp_en),
                .nxt_sel  (nxt_sel[i]),
                .nxt_pass (nxt_pass[i]),
                .q        (flag_q[i])
            );
        end
    endgenerate

    assign mdn_out_n   = flag_q[F_MDN];
    assign mup_out_n   = flag_q[F_MUP];
    assign mm_out_n    = flag_q[F_MM];
    assign sys_match_n = flag_q[F_SYS];
    assign full_out_n  = flag_q[F_FULL];
    assign cdn_out     = flag_q[F_CDN];
    assign cup_out     = flag_q[F_CUP];

    // R5: the separately registered system flag mirrors the down flag
    assert_sys_mirror_R5: assert property (@(posedge clk) disable iff (rst)
        sys_match_n == mdn_out_n);

    // R2 / R3: a local hit on a compare asserts both match directions
    assert_hit_down_R2: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && cmp_en && loc_hit) |=> !mdn_out_n);
    assert_hit_up_R3: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && cmp_en && loc_hit) |=> !mup_out_n);

    // R4: a hit behind an upstream match is a multiple match
    assert_multi_chain_R4: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && cmp_en && loc_hit && !mdn_in_n) |=> !mm_out_n);

    // R7: a slice that is not locally full releases the full flag
    assert_not_full_R7: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !loc_full) |=> full_out_n);

    // R10: a hit raises both cascade claims
    assert_claim_R10: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && cmp_en && loc_hit) |=> (cdn_out && cup_out));

endmodule

// File: tb/tcam_casc_flags_tb.sv
module tcam_casc_flags_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_n = 1'b0, cmp_en = 1'b0;
    logic loc_hit = 1'b0, loc_multi = 1'b0, loc_full = 1'b0;
    logic mdn_in_n = 1'b1, mup_in_n = 1'b1, mm_in_n = 1'b1, full_in_n = 1'b0;
    logic cdn_in = 1'b0, cup_in = 1'b0;

    // output vector order: {mdn, mup, mm, sys, full, cdn, cup}
    logic mdn_c, mup_c, mm_c, full_c, cdn_c, cup_c, sys_c;
    logic mdn_s, mup_s, mm_s, full_s, cdn_s, cup_s, sys_s;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    tcam_casc_flags #(.CASCADE(1'b1)) u_dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .cmp_en(cmp_en),
        .loc_hit(loc_hit), .loc_multi(loc_multi), .loc_full(loc_full),
        .mdn_in_n(mdn_in_n), .mup_in_n(mup_in_n), .mm_in_n(mm_in_n),
        .full_in_n(full_in_n), .cdn_in(cdn_in), .cup_in(cup_in),
        .mdn_out_n(mdn_c), .mup_out_n(mup_c), .mm_out_n(mm_c),
        .full_out_n(full_c), .cdn_out(cdn_c), .cup_out(cup_c),
        .sys_match_n(sys_c)
    );

    tcam_casc_flags #(.CASCADE(1'b0)) u_solo (
        .clk(clk), .rst(rst), .sel_n(sel_n), .cmp_en(cmp_en),
        .loc_hit(loc_hit), .loc_multi(loc_multi), .loc_full(loc_full),
        .mdn_in_n(mdn_in_n), .mup_in_n(mup_in_n), .mm_in_n(mm_in_n),
        .full_in_n(full_in_n), .cdn_in(cdn_in), .cup_in(cup_in),
        .mdn_out_n(mdn_s), .mup_out_n(mup_s), .mm_out_n(mm_s),
        .full_out_n(full_s), .cdn_out(cdn_s), .cup_out(cup_s),
        .sys_match_n(sys_s)
    );

    typedef struct {
        logic [6:0] exp_c;
        logic [6:0] exp_s;
        string      tag;
    } item_t;

    item_t      sb_q[$];
    logic [6:0] model_c = 7'b1111100;
    logic [6:0] model_s = 7'b1111100;

    function automatic logic [6:0] predict(input logic [6:0] old, input bit casc,
        input logic s, c, h, m, f, md, mu, mm, fi, cd, cu);
        logic [6:0] r;
        r = old;
        if (s) begin
            if (casc) r = {md, mu, mm, md, fi, cd, cu};
            else      r = 7'b1111000;
        end else begin
            r[2] = ~(f & ~fi);
            if (c) begin
                r[6] = ~(h | ~md);
                r[5] = ~(h | ~mu);
                r[4] = ~(m | ~mm | (h & ~md));
                r[3] = ~(h | ~md);
                r[1] = cd | h;
                r[0] = cu | h;
            end
        end
        return r;
    endfunction

    task automatic report(input string tag, input string who,
                          input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s): actual=%b expected=%b", tag, who, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and queues what must follow
    task automatic step(input logic s, c, h, m, f, md, mu, mm, fi, cd, cu,
                        input string tag);
        item_t it;
        @(negedge clk);
        sel_n = s; cmp_en = c; loc_hit = h; loc_multi = m; loc_full = f;
        mdn_in_n = md; mup_in_n = mu; mm_in_n = mm; full_in_n = fi;
        cdn_in = cd; cup_in = cu;
        model_c = predict(model_c, 1'b1, s, c, h, m, f, md, mu, mm, fi, cd, cu);
        model_s = predict(model_s, 1'b0, s, c, h, m, f, md, mu, mm, fi, cd, cu);
        it.exp_c = model_c;
        it.exp_s = model_s;
        it.tag   = tag;
        sb_q.push_back(it);
    endtask

    // monitor: compares after each edge once something is queued
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                report(it.tag, "chained",
                       {mdn_c, mup_c, mm_c, sys_c, full_c, cdn_c, cup_c}, it.exp_c);
                report(it.tag, "standalone",
                       {mdn_s, mup_s, mm_s, sys_s, full_s, cdn_s, cup_s}, it.exp_s);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset levels while reset is held
        report("R1", "chained",
               {mdn_c, mup_c, mm_c, sys_c, full_c, cdn_c, cup_c}, 7'b1111100);
        report("R1", "standalone",
               {mdn_s, mup_s, mm_s, sys_s, full_s, cdn_s, cup_s}, 7'b1111100);
        rst = 1'b0;
        //   sel cmp hit mul ful mdi mui mmi ffi cdi cui
        step(0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0, "R1 idle after release");
        step(0, 1, 0, 0, 0, 1, 1, 1, 0, 0, 0, "R2 no hit no upstream");
        step(0, 1, 1, 0, 0, 1, 1, 1, 0, 0, 0, "R2 R3 R10 local hit");
        step(0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 1, "R6 hold without compare");
        step(0, 1, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R2 R5 upstream match only");
        step(0, 1, 0, 0, 0, 1, 0, 1, 0, 0, 1, "R3 R10 lower match only");
        step(0, 1, 1, 0, 0, 0, 1, 1, 0, 0, 0, "R4 hit behind upstream match");
        step(0, 1, 0, 1, 0, 1, 1, 1, 0, 0, 0, "R4 local multi");
        step(0, 1, 0, 0, 0, 1, 1, 0, 0, 1, 0, "R4 R10 upstream multi");
        step(0, 1, 0, 0, 0, 1, 1, 1, 0, 0, 0, "R4 clear");
        step(0, 0, 0, 0, 1, 1, 1, 1, 0, 0, 0, "R7 full with upstream full");
        step(0, 0, 0, 0, 1, 1, 1, 1, 1, 0, 0, "R7 full but upstream not full");
        step(0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0, "R7 not full");
        step(1, 0, 1, 1, 1, 0, 1, 0, 1, 1, 0, "R8 R9 deselect pattern a");
        step(1, 1, 0, 0, 0, 1, 0, 1, 0, 0, 1, "R8 R9 deselect pattern b");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R8 R9 deselect pattern c");
        step(0, 1, 0, 0, 1, 1, 1, 1, 0, 0, 0, "R2 R7 reselect");
        step(0, 0, 1, 1, 0, 0, 0, 0, 1, 1, 1, "R6 inputs ignored without compare");
        step(0, 1, 1, 1, 0, 0, 0, 0, 0, 1, 1, "R4 R5 everything asserted");
        step(0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0, "R6 final hold");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule